// File: doc/BRIEF.md
# Montgomery Modulus Coefficient Generator

This block takes an odd modulus N of `len` words and computes the coefficient R for Montgomery reduction. R satisfies R·N ≡ −1 (mod 2^n), where n = len × WORD_W. The host writes N into a word memory, sets `len` and pulses `start`. The block reads the modulus one word at a time and forms −N as the bitwise complement plus one. It then grows R one bit at a time. Before each bit step it sets a power-of-two register to 2^k. It forms the truncated product T = R·(−N) one word multiply at a time and tests bit k of T. When that bit is set, it adds the power of two to R. When the last bit position is done, it writes R to an output word memory, least significant word first, and pulses `done`.

The invariant is R·(−N) ≡ 1 (mod 2^k). If bit k of T is set, adding 2^k·(−N) flips it, because −N is odd. The loop therefore needs only one bit test per position and no division. When parameter `TRUNC_COLS` is set, the product is only formed up to the word column that holds bit k. Columns above that one cannot affect the tested bit.

Top module: `mont_coef_gen`

## Requirements
- R1: After reset, and until `start` is pulsed, `done`, `n_rd_en` and `r_wr_en` are all 0.
- R2: A `start` pulse while idle latches `len` and starts the read. `n_rd_en` is asserted for `len` consecutive cycles at addresses 0, 1, …, len−1. The data for each address is taken from `n_rd_data` in the cycle after the request.
- R3: The result is written over `len` consecutive cycles at addresses 0 … len−1, least significant 32-bit word at address 0. The value satisfies (R·N + 1) mod 2^(32·len) = 0, with 0 ≤ R < 2^(32·len).
- R4: `done` is high for exactly one cycle, in the cycle right after the last result write. It pulses once per run.
- R5: A `start` pulse while a run is in progress is ignored. It causes no second read of the modulus, no second `done` pulse and no change to the result.
- R6: Every length from 1 to MAX_WORDS gives a correct result. A change on the `len` input after `start` has no effect on the run in progress.
- R7: Boundary moduli give exact values. N = 1 gives R = 2^n − 1 (all ones). N = 2^n − 1 gives R = 1. N = 3 with len = 1 gives R = 0x55555555.
- R8: Read requests and result writes never overlap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| len | input | LEN_W (4) | Modulus length in words, 1..MAX_WORDS |
| n_rd_en | output | 1 | Modulus memory read request |
| n_rd_addr | output | IDX_W (3) | Modulus word address |
| n_rd_data | input | WORD_W (32) | Modulus word, valid the cycle after the request |
| r_wr_en | output | 1 | Result memory write strobe |
| r_wr_addr | output | IDX_W (3) | Result word address |
| r_wr_data | output | WORD_W (32) | Result word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every length from one to eight words with random odd moduli. It checks each result through the defining congruence, computed with 256-bit arithmetic in the bench. If a carry was dropped between words, in the negation, the add or the multiply, the congruence would fail, usually in the upper words only. The moduli 1 and all-ones push the conditional add to always fire and to never fire. They expose a wrong power-of-two position or a bad end of the loop as a wrong exact value. Runs that pulse `start` and change `len` mid-run expose a block that restarts or picks up the new length: it would read the memory twice, pulse `done` twice or write the wrong number of words.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_CLR,
      ST_MAC,
      ST_PICK,
      ST_ADD,
      ST_WRITE
   } mcg_state_e;
endpackage

// File: rtl/mcg_word_add.sv
module mcg_word_add #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
endmodule

// File: rtl/mcg_word_mac.sv
module mcg_word_mac #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] t,
   input  logic [W-1:0] c,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic [2*W-1:0] full;
   // (2^W-1)^2 + 2(2^W-1) = 2^2W - 1, so the sum never overflows 2W bits
   assign full = ({{W{1'b0}}, a} * {{W{1'b0}}, b}) + {{W{1'b0}}, t} + {{W{1'b0}}, c};
   assign lo = full[W-1:0];
   assign hi = full[2*W-1:W];
endmodule

// File: rtl/mont_coef_gen.sv
module mont_coef_gen
   import mcg_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int MAX_WORDS  = 8,
   parameter bit TRUNC_COLS = 1'b1,
   localparam int IDX_W     = $clog2(MAX_WORDS),
   localparam int LEN_W     = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  len,
   output logic              n_rd_en,
   output logic [IDX_W-1:0]  n_rd_addr,
   input  logic [WORD_W-1:0] n_rd_data,
   output logic              r_wr_en,
   output logic [IDX_W-1:0]  r_wr_addr,
   output logic [WORD_W-1:0] r_wr_data,
   output logic              done
);
   localparam int SEL_W = $clog2(WORD_W);
   localparam int K_W   = IDX_W + SEL_W;

   // elaboration-time parameter checks
   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 8");
   end
   if (MAX_WORDS < 2 || (MAX_WORDS & (MAX_WORDS - 1)) != 0) begin : g_bad_depth
      $error("MAX_WORDS must be a power of two of at least 2");
   end

   mcg_state_e        state_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  i_q, j_q;
   logic [K_W-1:0]    k_q;
   logic [WORD_W-1:0] mc_q;
   logic              neg_c_q;
   logic              ac_q;
   logic              done_q;

   logic [WORD_W-1:0] nn_q [MAX_WORDS];
   logic [WORD_W-1:0] r_q  [MAX_WORDS];
   logic [WORD_W-1:0] b_q  [MAX_WORDS];
   logic [WORD_W-1:0] t_q  [MAX_WORDS];
   logic [WORD_W-1:0] b_shl[MAX_WORDS];

   // derived indices
   logic [LEN_W-1:0] len_m1_full;
   logic [IDX_W-1:0] len_m1;
   logic [LEN_W-1:0] ld_full;
   logic [IDX_W-1:0] ld_ix;
   logic [IDX_W-1:0] wi;
   logic [SEL_W-1:0] bpos;
   logic [IDX_W-1:0] lim;
   logic [IDX_W-1:0] col;
   logic [K_W:0]     nbits;
   logic [K_W:0]     nbits_m1;
   logic             k_last;
   logic             row_end;

   assign len_m1_full = len_q - {{(LEN_W-1){1'b0}}, 1'b1};
   assign len_m1      = len_m1_full[IDX_W-1:0];
   assign ld_full     = cnt_q - {{(LEN_W-1){1'b0}}, 1'b1};
   assign ld_ix       = ld_full[IDX_W-1:0];
   assign wi          = k_q[K_W-1:SEL_W];
   assign bpos        = k_q[SEL_W-1:0];
   assign col         = i_q + j_q;
   assign row_end     = (j_q == (lim - i_q));
   assign nbits       = {len_q, {SEL_W{1'b0}}};
   assign nbits_m1    = nbits - {{K_W{1'b0}}, 1'b1};
   assign k_last      = ({1'b0, k_q} == nbits_m1);

   // product column limit: stop at the decision word, or span all words
   if (TRUNC_COLS) begin : g_trunc
      assign lim = wi;
   end else begin : g_full
      assign lim = len_m1;
   end

   // one-bit left shift of the power-of-two register across words
   for (genvar g = 0; g < MAX_WORDS; g++) begin : g_shift
      if (g == 0) begin : g_lsw
         assign b_shl[g] = {b_q[g][WORD_W-2:0], 1'b0};
      end else begin : g_upper
         assign b_shl[g] = {b_q[g][WORD_W-2:0], b_q[g-1][WORD_W-1]};
      end
   end

   // arithmetic units
   logic [WORD_W-1:0] neg_sum;
   logic              neg_co;
   mcg_word_add #(.W(WORD_W)) u_neg (
      .a(~n_rd_data), .b('0), .cin(neg_c_q), .sum(neg_sum), .cout(neg_co)
   );

   logic [WORD_W-1:0] add_sum;
   logic              add_co;
   mcg_word_add #(.W(WORD_W)) u_acc (
      .a(r_q[j_q]), .b(b_q[j_q]), .cin(ac_q), .sum(add_sum), .cout(add_co)
   );

   logic [WORD_W-1:0] mac_lo, mac_hi;
   mcg_word_mac #(.W(WORD_W)) u_mac (
      .a(r_q[j_q]), .b(nn_q[i_q]), .t(t_q[col]), .c(mc_q), .lo(mac_lo), .hi(mac_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         cnt_q   <= '0;
         i_q     <= '0;
         j_q     <= '0;
         k_q     <= '0;
         mc_q    <= '0;
         neg_c_q <= 1'b0;
         ac_q    <= 1'b0;
         done_q  <= 1'b0;
         for (int g = 0; g < MAX_WORDS; g++) begin
            nn_q[g] <= '0;
            r_q[g]  <= '0;
            b_q[g]  <= '0;
            t_q[g]  <= '0;
         end
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  len_q   <= len;
                  cnt_q   <= '0;
                  neg_c_q <= 1'b1;
                  k_q     <= {{(K_W-1){1'b0}}, 1'b1};
                  for (int g = 0; g < MAX_WORDS; g++) begin
                     r_q[g] <= (g == 0) ? {{(WORD_W-1){1'b0}}, 1'b1} : '0;
                     b_q[g] <= (g == 0) ? {{(WORD_W-1){1'b0}}, 1'b1} : '0;
                  end
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (cnt_q != '0) begin
                  nn_q[ld_ix] <= neg_sum;
                  neg_c_q     <= neg_co;
               end
               if (cnt_q == len_q) state_q <= ST_CLR;
               else                cnt_q   <= cnt_q + {{(LEN_W-1){1'b0}}, 1'b1};
            end
            ST_CLR: begin
               for (int g = 0; g < MAX_WORDS; g++) begin
                  b_q[g] <= b_shl[g];
                  t_q[g] <= '0;
               end
               i_q     <= '0;
               j_q     <= '0;
               mc_q    <= '0;
               state_q <= ST_MAC;
            end
            ST_MAC: begin
               t_q[col] <= mac_lo;
               if (row_end) begin
                  mc_q <= '0;
                  j_q  <= '0;
                  if (i_q == lim) state_q <= ST_PICK;
                  else            i_q     <= i_q + {{(IDX_W-1){1'b0}}, 1'b1};
               end else begin
                  mc_q <= mac_hi;
                  j_q  <= j_q + {{(IDX_W-1){1'b0}}, 1'b1};
               end
            end
            ST_PICK: begin
               if (t_q[wi][bpos]) begin
                  j_q     <= '0;
                  ac_q    <= 1'b0;
                  state_q <= ST_ADD;
               end else if (k_last) begin
                  j_q     <= '0;
                  state_q <= ST_WRITE;
               end else begin
                  k_q     <= k_q + {{(K_W-1){1'b0}}, 1'b1};
                  state_q <= ST_CLR;
               end
            end
            ST_ADD: begin
               r_q[j_q] <= add_sum;
               ac_q     <= add_co;
               if (j_q != len_m1) begin
                  j_q <= j_q + {{(IDX_W-1){1'b0}}, 1'b1};
               end else if (k_last) begin
                  j_q     <= '0;
                  state_q <= ST_WRITE;
               end else begin
                  k_q     <= k_q + {{(K_W-1){1'b0}}, 1'b1};
                  state_q <= ST_CLR;
               end
            end
            ST_WRITE: begin
               if (j_q == len_m1) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  j_q <= j_q + {{(IDX_W-1){1'b0}}, 1'b1};
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign n_rd_en   = (state_q == ST_LOAD) && (cnt_q < len_q);
   assign n_rd_addr = cnt_q[IDX_W-1:0];
   assign r_wr_en   = (state_q == ST_WRITE);
   assign r_wr_addr = j_q;
   assign r_wr_data = r_q[j_q];
   assign done      = done_q;
endmodule

// File: rtl/mcg_checker.sv
module mcg_checker #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             n_rd_en,
   input logic [IDX_W-1:0] n_rd_addr,
   input logic             r_wr_en,
   input logic [IDX_W-1:0] r_wr_addr
);
   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!done && !n_rd_en && !r_wr_en));

   assert_rd_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(n_rd_en) |-> (n_rd_addr == '0));

   assert_rd_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (n_rd_en && $past(n_rd_en)) |-> (n_rd_addr == IDX_W'($past(n_rd_addr) + 1'b1)));

   assert_wr_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(r_wr_en) |-> (r_wr_addr == '0));

   assert_wr_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (r_wr_en && $past(r_wr_en)) |-> (r_wr_addr == IDX_W'($past(r_wr_addr) + 1'b1)));

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(r_wr_en) && !r_wr_en));

   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(n_rd_en && r_wr_en));
endmodule

bind mont_coef_gen mcg_checker #(.IDX_W(IDX_W)) i_mcg_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .n_rd_en  (n_rd_en),
   .n_rd_addr(n_rd_addr),
   .r_wr_en  (r_wr_en),
   .r_wr_addr(r_wr_addr)
);

// File: tb/test_mont_coef_gen.sv
`timescale 1ns/1ps
module test_mont_coef_gen;
   localparam int W  = 32;
   localparam int MW = 8;
   localparam int IW = 3;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LW-1:0] len = '0;
   logic          n_rd_en;
   logic [IW-1:0] n_rd_addr;
   logic [W-1:0]  n_rd_data = '0;
   logic          r_wr_en;
   logic [IW-1:0] r_wr_addr;
   logic [W-1:0]  r_wr_data;
   logic          done;

   always #2 clk = ~clk;

   mont_coef_gen i_mont_coef_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .len(len),
      .n_rd_en(n_rd_en), .n_rd_addr(n_rd_addr), .n_rd_data(n_rd_data),
      .r_wr_en(r_wr_en), .r_wr_addr(r_wr_addr), .r_wr_data(r_wr_data),
      .done(done)
   );

   int tests = 0;
   int fails = 0;

   logic [W-1:0]  nmem [MW];
   logic [W-1:0]  rmem [MW];
   int            rd_cnt, rd_bad, wr_cnt, wr_bad, done_cnt, done_bad;
   logic          pend_en = 1'b0;
   logic [IW-1:0] pend_addr = '0;
   logic          prev_wr = 1'b0;

   // sample outputs away from the active edge
   always @(negedge clk) begin
      pend_en   <= n_rd_en;
      pend_addr <= n_rd_addr;
      if (n_rd_en) begin
         if (int'(n_rd_addr) != rd_cnt) rd_bad++;
         rd_cnt++;
      end
      if (r_wr_en) begin
         if (int'(r_wr_addr) != wr_cnt) wr_bad++;
         rmem[r_wr_addr] = r_wr_data;
         wr_cnt++;
      end
      if (done) begin
         done_cnt++;
         if (!prev_wr) done_bad++;
      end
      prev_wr <= r_wr_en;
   end

   // modulus memory: one-cycle read latency
   always @(posedge clk) begin
      if (pend_en) n_rd_data <= nmem[pend_addr];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_case(input int l, input logic [255:0] nv, input bit poke,
                           input bit exact, input logic [255:0] rexp, input string req);
      logic [255:0] mask, rv, prod;
      int cyc;
      for (int w = 0; w < MW; w++) begin
         nmem[w] = nv[32*w +: 32];
         rmem[w] = '0;
      end
      rd_cnt = 0; rd_bad = 0; wr_cnt = 0; wr_bad = 0; done_cnt = 0; done_bad = 0;
      @(negedge clk);
      len   = LW'(l);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      len   = LW'((l % MW) + 1);   // R6: change after start must not matter
      cyc = 0;
      while (done_cnt == 0 && cyc < 40000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 60) begin
            start = 1'b1;          // R5: mid-run start
            len   = LW'(1);
         end else begin
            start = 1'b0;
         end
      end
      chk(done_cnt != 0, req, "watchdog: done never pulsed", 256'(cyc), 256'd0);
      repeat (60) @(negedge clk);
      mask = (l == MW) ? '1 : ((256'd1 << (32 * l)) - 256'd1);
      rv = '0;
      for (int w = 0; w < MW; w++) rv[32*w +: 32] = rmem[w];
      prod = (rv * nv + 256'd1) & mask;
      chk(prod == '0, req, "R3 congruence R*N+1 mod 2^n", prod, 256'd0);
      chk(rd_cnt == l && rd_bad == 0, "R2", "modulus read count/order",
          256'(rd_cnt), 256'(l));
      chk(wr_cnt == l && wr_bad == 0, "R3", "result write count/order",
          256'(wr_cnt), 256'(l));
      chk(done_cnt == 1 && done_bad == 0, "R4", "single done after last write",
          256'(done_cnt), 256'd1);
      if (poke)
         chk(done_cnt == 1 && rd_cnt == l, "R5", "mid-run start ignored",
             256'(rd_cnt), 256'(l));
      if (exact)
         chk(rv == rexp, "R7", "exact boundary value", rv, rexp);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [255:0] nv;
      repeat (3) @(negedge clk);
      // R1: idle state under and after reset
      chk(!done && !n_rd_en && !r_wr_en, "R1", "outputs during reset",
          {253'd0, done, n_rd_en, r_wr_en}, 256'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!done && !n_rd_en && !r_wr_en, "R1", "outputs idle after reset",
          {253'd0, done, n_rd_en, r_wr_en}, 256'd0);

      // R6: sweep every length with random odd moduli
      for (int l = 1; l <= MW; l++) begin
         nv = '0;
         for (int w = 0; w < l; w++) nv[32*w +: 32] = $urandom;
         nv[0] = 1'b1;
         run_case(l, nv, (l == 3 || l == 6), 1'b0, '0, "R6");
      end
      for (int r = 0; r < 4; r++) begin
         nv = '0;
         nv[31:0] = $urandom | 32'd1;
         run_case(1, nv, 1'b0, 1'b0, '0, "R6");
      end
      // R7: boundary moduli
      run_case(3, 256'd1, 1'b0, 1'b1, (256'd1 << 96) - 256'd1, "R7");
      run_case(2, (256'd1 << 64) - 256'd1, 1'b0, 1'b1, 256'd1, "R7");
      run_case(1, 256'd3, 1'b0, 1'b1, 256'h55555555, "R7");
      run_case(MW, '1, 1'b1, 1'b1, 256'd1, "R7");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule